// File: doc/BRIEF.md
# Power-down and wakeup controller

This block holds the clock control byte of a small processor core and sequences its sleep and wakeup. Software writes the byte to pick the oscillators that run, the processor clock source and the clock divisor. Setting the top bit in the same write puts the core to sleep: the processor clock stops until a wakeup event arrives. A wakeup event is a level change on any of the monitored port pins, or an overflow pulse from the secondary timer while the secondary oscillator is enabled.

The controller samples the port pins through a two-stage synchronizer. When a write enters power-down, it captures the synchronized pin values, and any later difference from that snapshot, rising or falling, wakes the core. The primary oscillator may have been stopped during sleep while it is still the selected clock source. In that case the wakeup turns it back on and keeps the processor clock gated for a settling interval of `STAB_CYCLES` reference-clock cycles. The default is ten milliseconds at 14.32 MHz. The analog oscillators are outside the block. `clk_ready` is the gate enable for the processor clock.

Top module: `pwr_wake_ctl`

## Requirements
- R1: After reset `ctl_q` is 8'h01 (primary oscillator on, primary source, divisor field 0, awake) and `clk_ready` is 1.
- R2: A write while `clk_ready` is 1 loads `wr_data` into `ctl_q` on the next clock edge, with bit 6 forced to 0. Bit 0 is the primary oscillator enable, bit 1 the secondary oscillator enable, bit 2 the source select (0 primary, 1 secondary), bits 4:3 the divisor, bit 5 the fast clock enable and bit 7 power-down.
- R3: A write with bit 7 set enters power-down. The other bits take their written values in the same write, and `clk_ready` is 0 from the next cycle.
- R4: A write is ignored while in power-down and while the stabilization wait runs.
- R5: In power-down, a rising or falling change on any pin relative to its value at entry clears bit 7. The clear lands on the third rising clock edge after the pin changes.
- R6: A `t2_ovf` pulse clears bit 7 on the next edge only if bit 1 is set. Otherwise it has no effect, and it never has an effect while awake.
- R7: On wakeup with bit 2 = 0 and bit 0 = 0, bit 0 is set and `clk_ready` stays 0 for exactly `STAB_CYCLES` cycles after the edge that clears bit 7.
- R8: On wakeup with bit 0 = 1 or bit 2 = 1, bit 0 is unchanged and `clk_ready` is 1 right after the edge that clears bit 7.
- R9: `clk_ready` is 0 whenever bit 7 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, always running |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Value to write |
| pins | input | NPINS | Asynchronous port pins watched for wakeup |
| t2_ovf | input | 1 | One-cycle overflow pulse from the secondary timer |
| ctl_q | output | 8 | Current control byte |
| clk_ready | output | 1 | Processor clock enable |

## Verification
The assertions assume that `t2_ovf` is synchronous to `clk` and that the pins stay steady from the write that enters power-down until the snapshot has been taken through the synchronizer. The stimulus meets these assumptions by changing pins only on falling edges, several cycles after the power-down write. It also raises `t2_ovf` for a single cycle only. Writes made during sleep and during the settling wait use patterns that differ from the held value in every bit, so a write that leaked through would show at the port.

// File: rtl/pwr_wake_ctl.sv
module pwr_wake_ctl #(
  parameter int NPINS       = 16,
  parameter int STAB_CYCLES = 143200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [NPINS-1:0] pins,
  input  logic             t2_ovf,
  output logic [7:0]       ctl_q,
  output logic             clk_ready
);
  localparam int CW = $clog2(STAB_CYCLES + 1);

  logic [NPINS-1:0] sync1, sync2, snap;
  logic             waiting;
  logic [CW-1:0]    cnt;

  wire pd         = ctl_q[7];
  wire pin_change = (sync2 != snap);
  wire wake       = pd && (pin_change || (t2_ovf && ctl_q[1]));
  wire restart    = !ctl_q[2] && !ctl_q[0];

  assign clk_ready = !pd && !waiting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= '0;
      sync2   <= '0;
      snap    <= '0;
      ctl_q   <= 8'h01;
      waiting <= 1'b0;
      cnt     <= '0;
    end else begin
      sync1 <= pins;
      sync2 <= sync1;
      if (wake) begin
        ctl_q[7] <= 1'b0;
        if (restart) begin
          ctl_q[0] <= 1'b1;
          waiting  <= 1'b1;
          cnt      <= CW'(STAB_CYCLES);
        end
      end else if (waiting) begin
        if (cnt == CW'(1)) waiting <= 1'b0;
        cnt <= cnt - CW'(1);
      end else if (!pd && wr_en) begin
        ctl_q <= wr_data & 8'hBF;
        if (wr_data[7]) snap <= sync2;
      end
    end
  end

  assert_pd_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[7]) |-> $past(wr_en && wr_data[7]));

  assert_sleep_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pd && !wake) |=> $stable(ctl_q));

  assert_t2_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctl_q[7]) && !$past(pin_change)) |-> $past(t2_ovf && ctl_q[1]));

  assert_wait_osc_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(waiting) |-> (ctl_q[0] && !ctl_q[7] && $past(ctl_q[7])));

  assert_ready_after_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_ready) |-> !$past(ctl_q[7]) || !ctl_q[7]);

  assert_ready_low_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[7]) |-> !clk_ready);
endmodule

// File: tb/tb_pwr_wake_ctl.sv
module tb_pwr_wake_ctl;
  localparam int NP   = 16;
  localparam int STAB = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_data = '0;
  logic [NP-1:0] pins = '0;
  logic          t2_ovf = 1'b0;
  logic [7:0]    ctl_q;
  logic          clk_ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pwr_wake_ctl #(.NPINS(NP), .STAB_CYCLES(STAB)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .pins(pins), .t2_ovf(t2_ovf), .ctl_q(ctl_q), .clk_ready(clk_ready));

  // {write data, expected ctl_q, expected clk_ready}
  localparam logic [16:0] VEC [6] = '{
    {8'h3B, 8'h3B, 1'b1},
    {8'h7F, 8'h3F, 1'b1},
    {8'h00, 8'h00, 1'b1},
    {8'h1E, 8'h1E, 1'b1},
    {8'h47, 8'h07, 1'b1},
    {8'h01, 8'h01, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t2_pulse();
    t2_ovf = 1'b1;
    @(negedge clk);
    t2_ovf = 1'b0;
  endtask

  task automatic count_wait(output int n);
    n = 0;
    while (!clk_ready && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 ctl", ctl_q, 8'h01);
    chk("R1 ready", clk_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctl after release", ctl_q, 8'h01);

    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][16:9]);
      chk("R2 ctl", ctl_q, VEC[i][8:1]);
      chk("R2 ready", clk_ready, VEC[i][0]);
    end

    // sleep with both oscillators on, timer wake
    wr(8'h83);
    chk("R3 ctl", ctl_q, 8'h83);
    chk("R9 ready in sleep", clk_ready, 0);
    wr(8'h7C);
    chk("R4 write in sleep", ctl_q, 8'h83);
    t2_pulse();
    chk("R6 timer wake", ctl_q, 8'h03);
    chk("R8 ready at once", clk_ready, 1);

    // timer pulse while awake
    t2_pulse();
    chk("R6 awake pulse", ctl_q, 8'h03);

    // sleep with all clocks off; timer blocked; pin rise wakes
    wr(8'h80);
    repeat (3) @(negedge clk);
    t2_pulse();
    @(negedge clk);
    chk("R6 timer ignored", ctl_q, 8'h80);
    pins = 16'h0020;
    @(negedge clk);
    @(negedge clk);
    chk("R5 still asleep", ctl_q[7], 1);
    @(negedge clk);
    chk("R5 rise wakes", ctl_q[7], 0);
    chk("R7 osc1 set", ctl_q, 8'h01);
    count_wait(n);
    chk("R7 wait length", n, STAB);

    // falling pin, secondary source, primary off
    wr(8'h84);
    repeat (3) @(negedge clk);
    pins = 16'h0000;
    repeat (3) @(negedge clk);
    chk("R5 fall wakes", ctl_q, 8'h04);
    chk("R8 no wait on secondary", clk_ready, 1);

    // write during the settling wait is dropped
    wr(8'h80);
    repeat (3) @(negedge clk);
    pins = 16'h8000;
    repeat (3) @(negedge clk);
    chk("R7 osc1 set again", ctl_q, 8'h01);
    wr(8'hFE);
    chk("R4 write in wait", ctl_q, 8'h01);
    count_wait(n);
    chk("R7 second wait length", n, STAB - 1);
    chk("R4 after wait", ctl_q, 8'h01);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule